// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

A full-duplex asynchronous serial port with independent transmit and receive paths. The host pushes characters into a two-entry transmit queue and pops them from a four-entry receive queue through simple strobe-style ports. A shared prescaler derives a sixteen-times oversampling tick from the system clock. Character length, parity and stop length come from static configuration inputs.

The receiver validates each start edge at half a bit time and then samples every later bit at its centre. Parity, framing and overrun conditions are latched into sticky flags that the host clears. An RTS output tells the far end when the receive queue is full. A CTS input can hold back the transmitter.

A line-mode select routes the serial pins for test. In normal mode both directions run. In echo mode incoming data is mirrored to the output and also received. In local loop the transmitter feeds the receiver internally. In remote loop the input is mirrored out and the receiver sees an idle line. A masked interrupt output summarises the pending events.

Top module: `uart_xcvr`

## Requirements
- R1: A character is a low start bit, then 5, 6, 7 or 8 data bits (cfg_len = 0, 1, 2, 3) sent least significant bit first, then the optional parity bit and the stop period. The idle line is high. On receive, the character is stored with its unused upper bits at zero.
- R2: cfg_parity 1 selects even parity, 2 selects odd parity, and 0 or 3 selects no parity bit. Even parity makes the count of ones across data plus parity even.
- R3: With cfg_stop = v, the stop period lasts v+1 oversampling ticks (one bit is 16 ticks, so the maximum is two bits). Between back-to-back characters the line is high for that period plus one system clock.
- R4: The receiver confirms a start bit eight ticks after the falling edge and then samples each bit sixteen ticks apart. A completed character is written to the receive queue on a tick.
- R5: The oversampling tick occurs once every cfg_prescale+1 system clocks, so one bit lasts 16*(cfg_prescale+1) clocks.
- R6: The transmit queue holds 2 characters and raises tx_full when it is full; a write while it is full is dropped. The receive queue holds 4 characters and returns them in arrival order.
- R7: err_flags bit 0 latches a parity mismatch and bit 1 latches a stop bit sampled low. The character is still stored.
- R8: A character completed while the receive queue is full is discarded and sets err_flags bit 2. All three flags stay set until an err_clr pulse.
- R9: rts_n is high exactly while the receive queue is full. While cfg_flow_en is 1 and cts_n is high, no new character starts.
- R10: cfg_mode selects the line routing. 0 is normal. In 1 (echo), txd follows rxd one clock later and the receiver still runs. In 2 (local loop), the transmitter drives the receiver and txd stays high. In 3 (remote loop), txd follows rxd and the receiver sees an idle line.
- R11: irq_pend bits are: 0 receive data available, 1 transmit queue empty, 2 parity error, 3 framing error, 4 overrun. irq is 1 when any pending bit has its irq_mask bit set.
- R12: After reset, txd is high, both queues are empty, all error flags are clear and rts_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prescale | input | 16 | Tick divider minus one |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_parity | input | 2 | Parity select |
| cfg_stop | input | 5 | Stop length in ticks minus one |
| cfg_mode | input | 2 | Line routing mode |
| cfg_flow_en | input | 1 | Enable CTS gating of transmit |
| tx_data | input | 8 | Character to queue for sending |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_full | output | 1 | Transmit queue full |
| rx_data | output | 8 | Oldest received character |
| rx_valid | output | 1 | Receive queue not empty |
| rx_rd | input | 1 | Pop strobe for rx_data |
| err_clr | input | 1 | Clears all error flags |
| err_flags | output | 3 | Sticky overrun, framing and parity flags |
| irq_mask | input | 5 | Interrupt enable per source |
| irq_pend | output | 5 | Pending interrupt sources |
| irq | output | 1 | Masked interrupt request |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rts_n | output | 1 | Request to send, active low |
| cts_n | input | 1 | Clear to send, active low |

## Verification
Random characters cross the local loop under random lengths, parity settings, stop lengths and prescaler values, which separates data-masking and bit-ordering faults from timing faults. Frames driven onto rxd with deliberately wrong parity or a low stop bit show whether each error is attributed to the right flag. Frames sent out on txd and decoded by the bench show whether the parity bit is generated correctly. Directed cases cover the stop-gap length, a fifth character into a full receive queue, CTS hold-off with a third write into a full transmit queue, and the echo and remote routings, which differ only in whether the receiver gets the character.

// File: rtl/uart_pkg.sv
// Shared types and helpers for the serial transceiver.
// Assumes character lengths of 5..8 bits encoded as 0..3.
package uart_pkg;
    typedef enum logic [1:0] {MODE_NORMAL = 2'd0, MODE_ECHO = 2'd1,
                              MODE_LOCAL = 2'd2, MODE_REMOTE = 2'd3} line_mode_e;
    typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} frame_st_e;

    // True when the parity code selects a parity bit.
    function automatic logic par_on(input logic [1:0] par);
        return (par == 2'd1) || (par == 2'd2);
    endfunction

    // Parity bit for the used data bits; even unless the code says odd.
    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] len,
                                     input logic [1:0] par);
        logic p;
        p = ^(d & (8'hFF >> (2'd3 - len)));
        return (par == 2'd2) ? ~p : p;
    endfunction
endpackage

// File: rtl/uart_baud.sv
// Oversampling tick generator: one tick every div+1 clocks.
// Assumes div may change at any time; the counter wraps on >=.
module uart_baud #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] cnt;

    assign tick = (cnt >= div);

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_fifo.sv
// Synchronous queue with a first-word-through read port.
// Assumes DEPTH is a power of two, at least 2. Writes when full are
// dropped and reads when empty are ignored.
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp, cnt;

    assign cnt   = wp - rp;
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign rdata = mem[rp[AW-1:0]];

    // Pointer update on accepted writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr && !full) wp <= wp + 1'b1;
            if (rd && !empty) rp <= rp + 1'b1;
        end
    end

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (wr && !full) mem[wp[AW-1:0]] <= wdata;
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd) |=> full && $stable(wp));
endmodule

// File: rtl/uart_tx.sv
// Transmit framer: start, data LSB first, optional parity, stop.
// Assumes go is only asserted while a character is available; it pops
// the character in the same cycle it leaves idle.
module uart_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len,
    input  logic [1:0] par,
    input  logic [4:0] stop,
    input  logic       go,
    input  logic [7:0] data,
    output logic       pop,
    output logic       line
);
    import uart_pkg::*;

    frame_st_e  st;
    logic [4:0] sub;
    logic [2:0] idx;
    logic [7:0] sh;
    logic       pb;
    logic       last;

    assign pop  = (st == ST_IDLE) && go;
    assign last = (st == ST_STOP) ? (sub == stop) : (sub == 5'd15);

    // Frame sequencer and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; line <= 1'b1; sub <= '0; idx <= '0; sh <= '0; pb <= 1'b0;
        end else if (st == ST_IDLE) begin
            line <= 1'b1;
            if (go) begin
                sh   <= data;
                pb   <= par_bit(data, len, par);
                st   <= ST_START;
                line <= 1'b0;
                sub  <= '0;
            end
        end else if (tick) begin
            sub <= sub + 1'b1;
            if (last) begin
                sub <= '0;
                case (st)
                    ST_START: begin st <= ST_DATA; line <= sh[0]; idx <= '0; end
                    ST_DATA: begin
                        if (idx == 3'(len) + 3'd4) begin
                            st   <= par_on(par) ? ST_PAR : ST_STOP;
                            line <= par_on(par) ? pb : 1'b1;
                        end else begin
                            idx  <= idx + 1'b1;
                            sh   <= sh >> 1;
                            line <= sh[1];
                        end
                    end
                    ST_PAR:  begin st <= ST_STOP; line <= 1'b1; end
                    default: begin st <= ST_IDLE; line <= 1'b1; end
                endcase
            end
        end
    end

    p_idle_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !go) |=> (st == ST_IDLE) && line);
endmodule

// File: rtl/uart_rx.sv
// Receive deframer with 16x oversampling and mid-bit sampling.
// Assumes raw input may be asynchronous; it is synchronised here.
module uart_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       din,
    input  logic [1:0] len,
    input  logic [1:0] par,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    import uart_pkg::*;

    frame_st_e  st;
    logic       s1, s2, pb;
    logic [4:0] sub;
    logic [2:0] idx;
    logic [7:0] sh, al;

    assign al = sh >> (2'd3 - len);

    // Two-stage input synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin s1 <= 1'b1; s2 <= 1'b1; end
        else        begin s1 <= din;  s2 <= s1;   end
    end

    // Start detection, bit sampling and character completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; sub <= '0; idx <= '0; sh <= '0; pb <= 1'b0;
            done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == ST_IDLE) begin
                if (!s2) begin st <= ST_START; sub <= '0; end
            end else if (tick) begin
                sub <= sub + 1'b1;
                case (st)
                    ST_START: if (sub == 5'd7) begin
                        sub <= '0;
                        idx <= '0;
                        st  <= s2 ? ST_IDLE : ST_DATA;
                    end
                    ST_DATA: if (sub == 5'd15) begin
                        sub <= '0;
                        sh  <= {s2, sh[7:1]};
                        if (idx == 3'(len) + 3'd4) st <= par_on(par) ? ST_PAR : ST_STOP;
                        else idx <= idx + 1'b1;
                    end
                    ST_PAR: if (sub == 5'd15) begin
                        sub <= '0; pb <= s2; st <= ST_STOP;
                    end
                    default: if (sub == 5'd15) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                        data <= al;
                        ferr <= !s2;
                        perr <= par_on(par) && (pb != par_bit(al, len, par));
                    end
                endcase
            end
        end
    end

    p_done_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tick));
endmodule

// File: rtl/uart_xcvr.sv
// Top of the serial transceiver: queues, prescaler, framers, line-mode
// routing, sticky error flags and masked interrupt.
// Assumes configuration inputs change only while the line is idle.
module uart_xcvr #(
    parameter int PRESCALE_W = 16,
    parameter int RX_DEPTH   = 4,
    parameter int TX_DEPTH   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRESCALE_W-1:0] cfg_prescale,
    input  logic [1:0]            cfg_len,
    input  logic [1:0]            cfg_parity,
    input  logic [4:0]            cfg_stop,
    input  logic [1:0]            cfg_mode,
    input  logic                  cfg_flow_en,
    input  logic [7:0]            tx_data,
    input  logic                  tx_wr,
    output logic                  tx_full,
    output logic [7:0]            rx_data,
    output logic                  rx_valid,
    input  logic                  rx_rd,
    input  logic                  err_clr,
    output logic [2:0]            err_flags,
    input  logic [4:0]            irq_mask,
    output logic [4:0]            irq_pend,
    output logic                  irq,
    output logic                  txd,
    input  logic                  rxd,
    output logic                  rts_n,
    input  logic                  cts_n
);
    import uart_pkg::*;

    line_mode_e mode;
    logic       tick, tx_empty, tx_pop, tx_go, tx_line, tx_full_i;
    logic [7:0] tx_head, rx_char;
    logic       rx_in, rx_done, rx_perr, rx_ferr, rx_full, rx_empty;
    logic [2:0] err_set;

    assign mode  = line_mode_e'(cfg_mode);
    assign tx_go = !tx_empty && (!cfg_flow_en || !cts_n);

    uart_baud #(.PW(PRESCALE_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(cfg_prescale), .tick(tick));

    uart_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data), .rd(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full_i));

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .len(cfg_len), .par(cfg_parity),
        .stop(cfg_stop), .go(tx_go), .data(tx_head), .pop(tx_pop), .line(tx_line));

    // Receiver input selection per line mode.
    always_comb begin
        case (mode)
            MODE_LOCAL:  rx_in = tx_line;
            MODE_REMOTE: rx_in = 1'b1;
            default:     rx_in = rxd;
        endcase
    end

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .din(rx_in), .len(cfg_len),
        .par(cfg_parity), .done(rx_done), .data(rx_char), .perr(rx_perr), .ferr(rx_ferr));

    uart_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .wr(rx_done), .wdata(rx_char), .rd(rx_rd),
        .rdata(rx_data), .empty(rx_empty), .full(rx_full));

    // Registered serial output driver per line mode.
    always_ff @(posedge clk) begin
        if (!rst_n) txd <= 1'b1;
        else case (mode)
            MODE_NORMAL: txd <= tx_line;
            MODE_LOCAL:  txd <= 1'b1;
            default:     txd <= rxd;
        endcase
    end

    assign err_set = {rx_done && rx_full, rx_done && rx_ferr, rx_done && rx_perr};

    // Sticky error flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flags <= '0;
        else        err_flags <= (err_clr ? 3'b000 : err_flags) | err_set;
    end

    assign tx_full  = tx_full_i;
    assign rx_valid = !rx_empty;
    assign rts_n    = rx_full;
    assign irq_pend = {err_flags, tx_empty, !rx_empty};
    assign irq      = |(irq_pend & irq_mask);

    p_cts_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flow_en && cts_n) |-> !tx_pop);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
    p_echo_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ECHO) |=> (txd == $past(rxd)));
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 5'd0) |-> !irq);
endmodule

// File: tb/sim_uart_xcvr.sv
// Self-checking bench: seeded random traffic plus directed corner cases.
module sim_uart_xcvr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [15:0] ps = 16'd0;
    logic [1:0]  len = 2'd3, par = 2'd0, mode = 2'd0;
    logic [4:0]  stp = 5'd15;
    logic        flow = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0;
    logic        rxd = 1'b1, cts_n = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic [4:0]  irq_mask = 5'd0;
    logic        tx_full, rx_valid, irq, txd, rts_n;
    logic [7:0]  rx_data;
    logic [2:0]  err_flags;
    logic [4:0]  irq_pend;

    int  nchk = 0, nfail = 0, echo_mis = 0;
    bit  echo_chk = 1'b0, finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(ps), .cfg_len(len), .cfg_parity(par),
        .cfg_stop(stp), .cfg_mode(mode), .cfg_flow_en(flow), .tx_data(tx_data),
        .tx_wr(tx_wr), .tx_full(tx_full), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_rd(rx_rd), .err_clr(err_clr), .err_flags(err_flags), .irq_mask(irq_mask),
        .irq_pend(irq_pend), .irq(irq), .txd(txd), .rxd(rxd), .rts_n(rts_n), .cts_n(cts_n));

    function automatic logic [7:0] msk(input logic [7:0] d);
        return d & (8'hFF >> (2'd3 - len));
    endfunction
    function automatic logic pbit(input logic [7:0] d);
        return (par == 2'd2) ? ~(^msk(d)) : ^msk(d);
    endfunction
    function automatic bit has_par();
        return (par == 2'd1) || (par == 2'd2);
    endfunction
    function automatic int bclk();
        return 16 * (int'(ps) + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask
    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic send_bit(input logic b);
        rxd = b;
        wclk(bclk() / 2);
        if (echo_chk && txd !== b) echo_mis++;
        wclk(bclk() - bclk() / 2);
    endtask
    task automatic drive_frame(input logic [7:0] d, input bit badp, input bit bads);
        send_bit(1'b0);
        for (int i = 0; i < int'(len) + 5; i++) send_bit(d[i]);
        if (has_par()) send_bit(pbit(d) ^ badp);
        if (bads) begin
            rxd = 1'b0; wclk(3 * bclk() / 4);
            rxd = 1'b1; wclk(bclk() / 4 + bclk());
        end else begin
            send_bit(1'b1);
            wclk(bclk());
        end
    endtask
    task automatic write_tx(input logic [7:0] d);
        tx_data = d; tx_wr = 1'b1; wclk(1); tx_wr = 1'b0;
    endtask
    task automatic wait_rx(output bit got);
        got = 1'b0;
        for (int i = 0; i < 40 * bclk() && !got; i++) begin
            if (rx_valid) got = 1'b1; else wclk(1);
        end
    endtask
    task automatic read_rx(output logic [7:0] d);
        d = rx_data; rx_rd = 1'b1; wclk(1); rx_rd = 1'b0;
    endtask
    task automatic decode_tx(output logic [7:0] d, output logic pb, output logic sb);
        int t = 0;
        d = 8'h00; pb = 1'b0;
        while (txd && t < 40 * bclk()) begin wclk(1); t++; end
        wclk(bclk() / 2);
        for (int i = 0; i < int'(len) + 5; i++) begin wclk(bclk()); d[i] = txd; end
        if (has_par()) begin wclk(bclk()); pb = txd; end
        wclk(bclk()); sb = txd;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, r, q [4];
        logic       pb, sb;
        bit         got;
        int         t;
        void'($urandom(32'd5249));
        wclk(4);
        chk("R12 txd idle", txd, 1);
        chk("R12 rx empty", rx_valid, 0);
        chk("R12 tx not full", tx_full, 0);
        chk("R12 err clear", err_flags, 0);
        chk("R12 rts_n low", rts_n, 0);
        rst_n = 1'b1;
        wclk(2);
        chk("R11 pend after reset", irq_pend, 5'b00010);
        chk("R11 irq masked", irq, 0);
        irq_mask = 5'b00010; wclk(1);
        chk("R11 irq tx empty", irq, 1);
        irq_mask = 5'b00001; wclk(1);
        chk("R11 irq rx masked off", irq, 0);

        // R1 R2 R4 R5: random formats through the local loop.
        mode = 2'd2;
        for (int k = 0; k < 24; k++) begin
            len = 2'($urandom_range(3)); par = 2'($urandom_range(3));
            stp = 5'($urandom_range(31, 15)); ps = 16'($urandom_range(2));
            d = 8'($urandom);
            wclk(2);
            write_tx(d);
            wait_rx(got);
            chk("R4 local char arrives", got, 1);
            chk("R1 R5 local data", rx_data, msk(d));
            chk("R2 no parity error", err_flags, 0);
            chk("R10 local txd high", txd, 1);
            read_rx(r);
            wclk(bclk());
        end

        // R1 R2: transmitted frames decoded on txd in normal mode.
        mode = 2'd0;
        for (int k = 0; k < 8; k++) begin
            len = 2'($urandom_range(3)); par = 2'($urandom_range(2, 1));
            ps = 16'($urandom_range(2)); stp = 5'd15;
            d = 8'($urandom);
            wclk(2);
            write_tx(d);
            decode_tx(r, pb, sb);
            chk("R1 tx data", r, msk(d));
            chk("R2 tx parity bit", pb, pbit(d));
            chk("R3 tx stop high", sb, 1);
            wclk(2 * bclk());
        end

        // R3: line-high gap between back-to-back zero characters.
        len = 2'd3; par = 2'd0; ps = 16'd0;
        for (int k = 0; k < 3; k++) begin
            stp = (k == 0) ? 5'd15 : ((k == 1) ? 5'd31 : 5'd20);
            wclk(2);
            write_tx(8'h00); write_tx(8'h00);
            t = 0;
            while (txd) wclk(1);
            while (!txd) wclk(1);
            while (txd && t < 200) begin wclk(1); t++; end
            chk("R3 stop gap clocks", t, int'(stp) + 2);
            wclk(300);
        end

        // R7 R8: received frames with random parity and stop faults.
        for (int k = 0; k < 12; k++) begin
            bit bp, bs;
            len = 2'($urandom_range(3)); par = 2'($urandom_range(3));
            ps = 16'($urandom_range(2));
            d = 8'($urandom);
            bp = has_par() && ($urandom_range(1) == 1);
            bs = ($urandom_range(2) == 0);
            wclk(2);
            drive_frame(d, bp, bs);
            wait_rx(got);
            chk("R7 char stored", got, 1);
            chk("R7 rx data", rx_data, msk(d));
            chk("R7 error flags", err_flags, {1'b0, bs, bp});
            chk("R11 pend errors", irq_pend[3:2], {bs, bp});
            read_rx(r);
            wclk(20);
            chk("R8 flags sticky", err_flags, {1'b0, bs, bp});
            err_clr = 1'b1; wclk(1); err_clr = 1'b0;
            chk("R8 flags cleared", err_flags, 0);
        end

        // R6 R8 R9: fill the receive queue, then overrun it.
        len = 2'd3; par = 2'd0; ps = 16'd0;
        for (int k = 0; k < 4; k++) begin
            q[k] = 8'($urandom);
            drive_frame(q[k], 1'b0, 1'b0);
        end
        chk("R9 rts_n high when full", rts_n, 1);
        chk("R8 no overrun yet", err_flags[2], 0);
        drive_frame(8'hA5, 1'b0, 1'b0);
        chk("R8 overrun flag", err_flags[2], 1);
        chk("R11 pend overrun", irq_pend[4], 1);
        for (int k = 0; k < 4; k++) begin
            read_rx(r);
            chk("R6 rx order", r, q[k]);
        end
        chk("R8 extra char dropped", rx_valid, 0);
        chk("R9 rts_n low again", rts_n, 0);
        err_clr = 1'b1; wclk(1); err_clr = 1'b0;

        // R6 R9: CTS hold-off and a write into a full transmit queue.
        mode = 2'd2; flow = 1'b1; cts_n = 1'b1;
        write_tx(8'h11); write_tx(8'h22); write_tx(8'h33);
        chk("R6 tx full", tx_full, 1);
        wclk(400);
        chk("R9 cts holds transmit", rx_valid, 0);
        cts_n = 1'b0;
        wait_rx(got); read_rx(r);
        chk("R6 first queued", r, 8'h11);
        wait_rx(got); read_rx(r);
        chk("R6 second queued", r, 8'h22);
        wclk(600);
        chk("R6 third write dropped", rx_valid, 0);
        flow = 1'b0;

        // R10: echo keeps receiving, remote loop does not.
        mode = 2'd1; echo_chk = 1'b1; echo_mis = 0;
        drive_frame(8'h5C, 1'b0, 1'b0);
        chk("R10 echo mirrors rxd", echo_mis, 0);
        wait_rx(got);
        chk("R10 echo receives", got, 1);
        read_rx(r);
        chk("R10 echo data", r, 8'h5C);
        mode = 2'd3; echo_mis = 0;
        wclk(4);
        drive_frame(8'h3A, 1'b0, 1'b0);
        chk("R10 remote mirrors rxd", echo_mis, 0);
        wclk(200);
        chk("R10 remote receiver idle", rx_valid, 0);
        echo_chk = 1'b0;

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule